// File: doc/BRIEF.md
# PRG ROM Bank Switching Mapper

This block sits between a console CPU and a cartridge program ROM. It decodes CPU writes to the upper 32KB of the address map into a 5-bit control register and a 5-bit program bank register. Writes to the two character bank ranges are decoded but not stored. The block then turns every CPU read address in $8000-$FFFF into a physical ROM address made from a 16KB bank number and the 14-bit offset inside the window. It also drives the nametable A10 line that selects the picture memory mirroring.

Three program layouts are supported. One switches the high 16KB window and fixes the low window to bank 0. One switches the low 16KB window and fixes the high window to the last bank. One switches the whole 32KB as an even/odd pair. The switched bank is held as one full 16KB number. Mode changes therefore never lose it, and an odd bank comes back after a trip through 32KB mode, unless the bank register was written while in that mode. The ROM size is given at run time as a power-of-two bank mask.

Top module: `prg_bank_mapper`

## Requirements
- R1: Writes with address bit 15 low change nothing. In the upper half, bits 14:13 select the target: 00 control, 01 and 10 character banks (not stored here), 11 program bank. A character-bank write with data bit 7 low leaves the program mapping and the mirroring unchanged.
- R2: A write to any upper-half address with data bit 7 high is a reset. It sets control bits 3 and 2 to 1, keeps control bits 4, 1 and 0, and leaves the bank number unchanged.
- R3: After the reset input is released, $8000 maps to bank 0 and $C000 maps to the last bank (the mask value). Mirroring is vertical (control value 0x0E).
- R4: With control bit 3 = 1 and bit 2 = 0, $8000-$BFFF reads bank 0 and $C000-$FFFF reads the bank number.
- R5: With control bit 3 = 1 and bit 2 = 1, $8000-$BFFF reads the bank number and $C000-$FFFF reads the last bank (the mask value).
- R6: With control bit 3 = 0, control bit 2 has no effect. $8000 reads the even bank of the pair and $C000 the odd bank. A bank write in this mode drops data bit 0.
- R7: Toggling control bit 2 moves the current bank number, unchanged, into the newly switched window.
- R8: Entering 32KB mode selects the pair that contains the bank previously in the switched window.
- R9: Leaving 32KB mode puts the even bank of the pair in the switched window if the bank register was written during 32KB mode. Otherwise the bank held before entry returns, odd or even. Control writes, character-bank writes and resets do not cancel this.
- R10: The ROM address is {window bank AND bank mask, cpu_addr[13:0]}.
- R11: Control bit 1 = 0 holds nametable A10 low and ignores bit 0. With bit 1 = 1, bit 0 = 0 passes PPU A10 (vertical) and bit 0 = 1 passes PPU A11 (horizontal).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address for writes and reads |
| wr_data | input | 8 | CPU write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rom_bank_mask | input | BANK_W | ROM bank count minus one (power-of-two count) |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| rom_addr | output | BANK_W+14 | Physical program ROM address |
| nt_a10 | output | 1 | Nametable memory A10 select |

## Verification
The bench builds the block with the default BANK_W of 5, which reaches all 32 bank numbers a 5-bit register can name. With that width, an odd bank such as 9 can travel through 32KB mode and back, and the fixed last bank (31) differs from every switched value. Most tests drive a full mask of 0x1F. A final test narrows the mask to 0x07, so that a bank of 10 folds to 2 and the last bank becomes 7.

// File: rtl/prg_mapper_pkg.sv
package prg_mapper_pkg;

   localparam int REG_W     = 5;
   localparam int WIN_OFS_W = 14;

   typedef struct packed {
      logic chr_4k;
      logic prg_16k;
      logic prg_low_sw;
      logic hv_mirror;
      logic mirror_horiz;
   } ctrl_t;

   localparam ctrl_t CTRL_POWER_ON = '{chr_4k: 1'b0, prg_16k: 1'b1, prg_low_sw: 1'b1,
                                       hv_mirror: 1'b1, mirror_horiz: 1'b0};

   typedef enum logic [2:0] {
      TGT_NONE,
      TGT_CTRL,
      TGT_CHR_A,
      TGT_CHR_B,
      TGT_PRG
   } wr_tgt_e;

endpackage

// File: rtl/prg_write_decode.sv
module prg_write_decode
   import prg_mapper_pkg::*;
(
   input  logic [2:0]       addr_hi,
   input  logic             data_msb,
   input  logic             wr_en,
   output wr_tgt_e          tgt,
   output logic             rst_req
);

   always_comb begin
      tgt = TGT_NONE;
      if (wr_en && addr_hi[2]) begin
         unique case (addr_hi[1:0])
            2'b00:   tgt = TGT_CTRL;
            2'b01:   tgt = TGT_CHR_A;
            2'b10:   tgt = TGT_CHR_B;
            default: tgt = TGT_PRG;
         endcase
      end
   end

   assign rst_req = (tgt != TGT_NONE) && data_msb;

endmodule

// File: rtl/prg_ctrl_bank_regs.sv
module prg_ctrl_bank_regs
   import prg_mapper_pkg::*;
#(
   parameter int BANK_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  wr_tgt_e           tgt,
   input  logic              rst_req,
   input  logic [REG_W-1:0]  wr_val,
   output ctrl_t             ctrl_q,
   output logic [BANK_W-1:0] bank_q
);

   localparam logic [BANK_W-1:0] BIT0 = BANK_W'(1);

   logic [BANK_W-1:0] bank_load;

   // In pair mode the lowest bank bit is not taken from the data
   assign bank_load = ctrl_q.prg_16k ? wr_val[BANK_W-1:0] : (wr_val[BANK_W-1:0] & ~BIT0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_POWER_ON;
         bank_q <= '0;
      end else if (rst_req) begin
         ctrl_q.prg_16k    <= 1'b1;
         ctrl_q.prg_low_sw <= 1'b1;
      end else if (tgt == TGT_CTRL) begin
         ctrl_q <= ctrl_t'(wr_val);
      end else if (tgt == TGT_PRG) begin
         bank_q <= bank_load;
      end
   end

endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
   import prg_mapper_pkg::*;
#(
   parameter int BANK_W = 5
) (
   input  ctrl_t                        ctrl_q,
   input  logic [BANK_W-1:0]            bank_q,
   input  logic [BANK_W-1:0]            bank_mask,
   input  logic [WIN_OFS_W:0]           cpu_addr,
   output logic [BANK_W+WIN_OFS_W-1:0]  rom_addr
);

   localparam int NUM_WIN = 2;
   localparam logic [BANK_W-1:0] BIT0 = BANK_W'(1);

   logic [BANK_W-1:0] win_bank [NUM_WIN];
   logic [BANK_W-1:0] sel_bank;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      logic [BANK_W-1:0] bank_w;
      always_comb begin
         if (!ctrl_q.prg_16k) begin
            bank_w = (w == 0) ? (bank_q & ~BIT0) : (bank_q | BIT0);
         end else if (ctrl_q.prg_low_sw) begin
            bank_w = (w == 0) ? bank_q : bank_mask;
         end else begin
            bank_w = (w == 0) ? '0 : bank_q;
         end
      end
      assign win_bank[w] = bank_w;
   end

   assign sel_bank = cpu_addr[WIN_OFS_W] ? win_bank[1] : win_bank[0];
   assign rom_addr = {sel_bank & bank_mask, cpu_addr[WIN_OFS_W-1:0]};

endmodule

// File: rtl/prg_mirror_sel.sv
module prg_mirror_sel (
   input  logic hv_mirror,
   input  logic mirror_horiz,
   input  logic ppu_a10,
   input  logic ppu_a11,
   output logic nt_a10
);

   always_comb begin
      if (!hv_mirror)        nt_a10 = 1'b0;
      else if (mirror_horiz) nt_a10 = ppu_a11;
      else                   nt_a10 = ppu_a10;
   end

endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
   import prg_mapper_pkg::*;
#(
   parameter int BANK_W = 5,
   localparam int AW    = BANK_W + WIN_OFS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        wr_data,
   input  logic              wr_en,
   input  logic [BANK_W-1:0] rom_bank_mask,
   input  logic              ppu_a10,
   input  logic              ppu_a11,
   output logic [AW-1:0]     rom_addr,
   output logic              nt_a10
);

   if (BANK_W < 1 || BANK_W > REG_W) begin : g_bad_width
      $error("prg_bank_mapper: BANK_W must lie in 1..%0d", REG_W);
   end

   wr_tgt_e           tgt;
   logic              rst_req;
   ctrl_t             ctrl_q;
   logic [BANK_W-1:0] bank_q;
   logic [2:0]        unused_bits;

   assign unused_bits = {wr_data[6:5], ctrl_q.chr_4k};

   prg_write_decode u_dec (
      .addr_hi  (cpu_addr[15:13]),
      .data_msb (wr_data[7]),
      .wr_en    (wr_en),
      .tgt      (tgt),
      .rst_req  (rst_req)
   );

   prg_ctrl_bank_regs #(.BANK_W(BANK_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .tgt     (tgt),
      .rst_req (rst_req),
      .wr_val  (wr_data[REG_W-1:0]),
      .ctrl_q  (ctrl_q),
      .bank_q  (bank_q)
   );

   prg_window_map #(.BANK_W(BANK_W)) u_map (
      .ctrl_q    (ctrl_q),
      .bank_q    (bank_q),
      .bank_mask (rom_bank_mask),
      .cpu_addr  (cpu_addr[WIN_OFS_W:0]),
      .rom_addr  (rom_addr)
   );

   prg_mirror_sel u_mir (
      .hv_mirror    (ctrl_q.hv_mirror),
      .mirror_horiz (ctrl_q.mirror_horiz),
      .ppu_a10      (ppu_a10),
      .ppu_a11      (ppu_a11),
      .nt_a10       (nt_a10)
   );

endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk #(
   parameter int BANK_W = 5,
   localparam int AW    = BANK_W + 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic [15:0]       cpu_addr,
   input logic [7:0]        wr_data,
   input logic              wr_en,
   input logic [BANK_W-1:0] rom_bank_mask,
   input logic              ppu_a10,
   input logic              ppu_a11,
   input logic [AW-1:0]     rom_addr,
   input logic              nt_a10,
   input logic [4:0]        ctrl_q,
   input logic [BANK_W-1:0] bank_q
);

   logic [BANK_W-1:0] out_bank;
   logic [1:0]        unused_chk;

   assign out_bank   = rom_addr[AW-1:14];
   assign unused_chk = wr_data[6:5];

   p_low_half_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !cpu_addr[15]) |=> ($stable(ctrl_q) && $stable(bank_q)));

   p_reset_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cpu_addr[15] && wr_data[7]) |=>
      (ctrl_q[3:2] == 2'b11 && $stable(ctrl_q[4]) && $stable(ctrl_q[1:0]) && $stable(bank_q)));

   p_fixed_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[3:2] == 2'b10 && cpu_addr[15:14] == 2'b10) |-> (out_bank == '0));

   p_fixed_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[3:2] == 2'b11 && cpu_addr[15:14] == 2'b11) |-> (out_bank == rom_bank_mask));

   p_pair_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[3] && cpu_addr[15] && rom_bank_mask[0]) |-> (out_bank[0] == cpu_addr[14]));

   p_pair_write_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cpu_addr[15:13] == 3'b111 && !wr_data[7] && !ctrl_q[3]) |=> !bank_q[0]);

   p_ctrl_keeps_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cpu_addr[15:13] == 3'b100) |=> $stable(bank_q));

   p_offset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_addr[15] |-> (rom_addr[13:0] == cpu_addr[13:0]));

   p_bank_in_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_bank & ~rom_bank_mask) == '0));

   p_one_screen_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[1] |-> !nt_a10);

   p_vertical_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[1:0] == 2'b10) |-> (nt_a10 == ppu_a10));

   p_horizontal_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[1:0] == 2'b11) |-> (nt_a10 == ppu_a11));

endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.BANK_W(BANK_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_addr      (cpu_addr),
   .wr_data       (wr_data),
   .wr_en         (wr_en),
   .rom_bank_mask (rom_bank_mask),
   .ppu_a10       (ppu_a10),
   .ppu_a11       (ppu_a11),
   .rom_addr      (rom_addr),
   .nt_a10        (nt_a10),
   .ctrl_q        (ctrl_q),
   .bank_q        (bank_q)
);

// File: tb/prg_bank_mapper_tb.sv
module prg_bank_mapper_tb;

   localparam int BANK_W = 5;
   localparam int AW     = BANK_W + 14;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [15:0]       cpu_addr = '0;
   logic [7:0]        wr_data = '0;
   logic              wr_en = 1'b0;
   logic [BANK_W-1:0] rom_bank_mask = 5'h1F;
   logic              ppu_a10 = 1'b0;
   logic              ppu_a11 = 1'b0;
   logic [AW-1:0]     rom_addr;
   logic              nt_a10;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   prg_bank_mapper #(.BANK_W(BANK_W)) u_dut (
      .clk (clk), .rst_n (rst_n), .cpu_addr (cpu_addr), .wr_data (wr_data),
      .wr_en (wr_en), .rom_bank_mask (rom_bank_mask), .ppu_a10 (ppu_a10),
      .ppu_a11 (ppu_a11), .rom_addr (rom_addr), .nt_a10 (nt_a10)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic expect_bank(input string req, input logic [15:0] a, input int exp);
      @(negedge clk);
      cpu_addr = a;
      #1;
      check(req, $sformatf("bank at %h", a), int'(rom_addr[AW-1:14]), exp);
      check(req, $sformatf("offset at %h", a), int'(rom_addr[13:0]), int'(a[13:0]));
   endtask

   task automatic expect_nt(input string req, input logic a10, input logic a11, input logic exp);
      @(negedge clk);
      ppu_a10 = a10; ppu_a11 = a11;
      #1;
      check(req, "nametable A10", int'(nt_a10), int'(exp));
   endtask

   task automatic t_power_on;   // R3
      expect_bank("R3", 16'h8000, 0);
      expect_bank("R3", 16'hC000, 31);
      expect_nt("R3", 1'b1, 1'b0, 1'b1);
      expect_nt("R3", 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_high_switch; // R4
      wr(16'h8000, 8'h0A);
      wr(16'hE000, 8'h06);
      expect_bank("R4", 16'h8000, 0);
      expect_bank("R4", 16'hBFFF, 0);
      expect_bank("R4", 16'hC000, 6);
      expect_bank("R4", 16'hFFFF, 6);
   endtask

   task automatic t_low_switch;  // R5, R7
      wr(16'h8000, 8'h0E);
      expect_bank("R7", 16'h8000, 6);
      expect_bank("R5", 16'hC000, 31);
      wr(16'hE000, 8'h09);
      expect_bank("R5", 16'h8123, 9);
   endtask

   task automatic t_pair_round_trip; // R6, R8, R9, R1, R2
      wr(16'h8000, 8'h02);
      expect_bank("R8", 16'h8000, 8);
      expect_bank("R8", 16'hC000, 9);
      wr(16'h8000, 8'h06);
      expect_bank("R6", 16'h8000, 8);
      expect_bank("R6", 16'hC000, 9);
      wr(16'h8000, 8'h0E);
      expect_bank("R9", 16'h8000, 9);
      wr(16'h8000, 8'h02);
      wr(16'hA000, 8'h03);
      wr(16'hC000, 8'h04);
      expect_bank("R1", 16'hC000, 9);
      wr(16'hE000, 8'h80);
      expect_bank("R9", 16'h8000, 9);
      expect_bank("R2", 16'hC000, 31);
      wr(16'h8000, 8'h02);
      wr(16'hE000, 8'h0B);
      expect_bank("R6", 16'h8000, 10);
      expect_bank("R6", 16'hC000, 11);
      wr(16'h8000, 8'h0A);
      expect_bank("R9", 16'hC000, 10);
      expect_bank("R9", 16'h8000, 0);
   endtask

   task automatic t_reset_write; // R2, R11
      wr(16'h8000, 8'h19);
      expect_nt("R11", 1'b1, 1'b1, 1'b0);
      expect_bank("R2", 16'hC000, 10);
      wr(16'hA000, 8'h80);
      expect_bank("R2", 16'h8000, 10);
      expect_bank("R2", 16'hC000, 31);
      expect_nt("R2", 1'b1, 1'b1, 1'b0);
   endtask

   task automatic t_mirroring;   // R11
      wr(16'h8000, 8'h0F);
      expect_nt("R11", 1'b1, 1'b0, 1'b0);
      expect_nt("R11", 1'b0, 1'b1, 1'b1);
      wr(16'h8000, 8'h0E);
      expect_nt("R11", 1'b1, 1'b0, 1'b1);
      expect_nt("R11", 1'b0, 1'b1, 1'b0);
   endtask

   task automatic t_low_half_writes; // R1
      wr(16'h6000, 8'h80);
      wr(16'h0000, 8'h05);
      wr(16'h7FFF, 8'h02);
      expect_bank("R1", 16'h8000, 10);
      expect_bank("R1", 16'hC000, 31);
      expect_nt("R1", 1'b1, 1'b0, 1'b1);
   endtask

   task automatic t_mask;        // R10
      @(negedge clk);
      rom_bank_mask = 5'h07;
      expect_bank("R10", 16'hC000, 7);
      expect_bank("R10", 16'h8123, 2);
      check("R10", "full address", int'(rom_addr), 32'h8123);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_power_on();
      t_high_switch();
      t_low_switch();
      t_pair_round_trip();
      t_reset_write();
      t_mirroring();
      t_low_half_writes();
      t_mask();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule